// File: doc/BRIEF.md
# Serial Receive Idle Time-out Counter

This block sits beside a serial receiver and detects a silent receive line. Software stores a 16-bit limit. A down-counter is loaded with that limit and steps down by one on each bit-period tick. When it reaches zero, a sticky time-out flag is raised, and an interrupt request follows it when interrupts are enabled. Each received character reloads the counter, so the flag marks a gap of the programmed length after the last character.

Two commands restart the function, and both clear the flag. The wait command stops the counter and loads the limit. Counting then starts only when the next character arrives, so a line that stays idle before a frame never times out. The restart command loads the limit and counts at once, so repeated use gives a periodic time-out with no characters at all. A limit of zero turns the whole function off. The baud generator, the receiver and the register decoding are outside the block and drive its strobes.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset the flag and the interrupt are low, the stored limit is 0, and the counter is stopped in the waiting state: with no character received, ticks never raise the flag, even after a nonzero limit is written.
- R2: While the stored limit is 0 the flag is low one cycle later, whatever the commands, characters or ticks. Writing 0 while the flag is set clears it.
- R3: With a limit N from 1 to 65535 loaded and the counter running, the flag rises after exactly N ticks, and not after N-1.
- R4: A character pulse while the flag is low reloads the counter with the limit and starts it.
- R5: Once set, the flag stays set and the counter holds at zero until a command. A character pulse or a tick has no effect on it.
- R6: The wait command clears the flag and stops the counter. Ticks then have no effect until a character is received, and N ticks after that character the flag rises.
- R7: The restart command clears the flag, loads the limit and counts immediately. Repeating it after each time-out gives one time-out every N ticks.
- R8: If a character pulse and a tick arrive in the same cycle, the reload wins and that tick is not counted.
- R9: A command in the same cycle as a character pulse overrides the character. If both commands arrive together, the wait command wins.
- R10: The interrupt output is high exactly when the flag is high and the interrupt enable input is high.
- R11: A newly written limit does not change a count in progress. It is used at the next reload.
- R12: The longest time-out, with a limit of 65535, raises the flag after exactly 65535 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| char_rx_i | input | 1 | One-cycle pulse when a character has been received |
| limit_i | input | 16 | Time-out limit in bit periods; 0 disables the function |
| limit_wr_i | input | 1 | Stores limit_i |
| wait_cmd_i | input | 1 | Clear the flag and wait for the next character |
| restart_cmd_i | input | 1 | Clear the flag, reload the counter and count now |
| irq_en_i | input | 1 | Interrupt enable |
| tmo_flag_o | output | 1 | Time-out status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Three pairs of events can fall in the same cycle: a character pulse with a tick, a command with a character pulse, and the two commands together. The bench places each pair on a single clock edge. It does this at a chosen point of the count, or while the flag is set. It then counts the further ticks needed to reach the flag. That count shows which event won: a reload that swallowed the tick needs the full limit again, and a wait command that beat a character leaves the counter stopped. A behavioural model follows every cycle and catches any difference in the edge where the flag changes.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  // Event that the counter acts on this cycle, after priority resolution
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_CHAR   = 2'd1,
    EV_RELOAD = 2'd2,
    EV_WAIT   = 2'd3
  } rxto_ev_e;
endpackage

// File: rtl/rxto_evt_sel.sv
module rxto_evt_sel
  import rxto_pkg::*;
(
  input  logic     wait_cmd_i,
  input  logic     restart_cmd_i,
  input  logic     char_rx_i,
  input  logic     flag_i,
  output rxto_ev_e ev_o
);
  // wait beats restart, any command beats a character,
  // a character is ignored while the flag is set
  always_comb begin
    if (wait_cmd_i)                ev_o = EV_WAIT;
    else if (restart_cmd_i)        ev_o = EV_RELOAD;
    else if (char_rx_i && !flag_i) ev_o = EV_CHAR;
    else                           ev_o = EV_NONE;
  end
endmodule

// File: rtl/rxto_limit_reg.sv
module rxto_limit_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] limit_o,
  output logic         active_o
);
  logic [W-1:0] lim_d, lim_q;

  always_comb begin
    lim_d = lim_q;
    if (wr_i) lim_d = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lim_q <= '0;
    else         lim_q <= lim_d;
  end

  assign limit_o  = lim_q;
  assign active_o = |lim_q;
endmodule

// File: rtl/rxto_countdown.sv
module rxto_countdown
  import rxto_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  rxto_ev_e     ev_i,
  input  logic         tick_i,
  input  logic         active_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] cnt_o,
  output logic         run_o,
  output logic         flag_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d, cnt_q;
  logic         run_d, run_q;
  logic         flag_d, flag_q;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    flag_d = flag_q;
    unique case (ev_i)
      EV_WAIT: begin
        flag_d = 1'b0;
        run_d  = 1'b0;
        cnt_d  = load_i;
      end
      EV_RELOAD: begin
        flag_d = 1'b0;
        run_d  = 1'b1;
        cnt_d  = load_i;
      end
      EV_CHAR: begin
        run_d = 1'b1;
        cnt_d = load_i;
      end
      default: begin
        if (tick_i && run_q && active_i) begin
          if (cnt_q <= ONE) begin
            cnt_d  = '0;
            run_d  = 1'b0;
            flag_d = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end
    endcase
    if (!active_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rxto_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             char_rx_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             limit_wr_i,
  input  logic             wait_cmd_i,
  input  logic             restart_cmd_i,
  input  logic             irq_en_i,
  output logic             tmo_flag_o,
  output logic             irq_o
);
  rxto_ev_e         ev;
  logic [CNT_W-1:0] lim_q;
  logic             lim_active;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             flag_q;

  rxto_limit_reg #(.W(CNT_W)) u_limit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (limit_wr_i),
    .data_i   (limit_i),
    .limit_o  (lim_q),
    .active_o (lim_active)
  );

  rxto_evt_sel u_sel (
    .wait_cmd_i    (wait_cmd_i),
    .restart_cmd_i (restart_cmd_i),
    .char_rx_i     (char_rx_i),
    .flag_i        (flag_q),
    .ev_o          (ev)
  );

  rxto_countdown #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .tick_i   (bit_tick_i),
    .active_i (lim_active),
    .load_i   (lim_q),
    .cnt_o    (cnt_q),
    .run_o    (run_q),
    .flag_o   (flag_q)
  );

  assign tmo_flag_o = flag_q;
  assign irq_o      = flag_q & irq_en_i;
endmodule

// File: rtl/rx_idle_timer_chk.sv
module rx_idle_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_tick_i,
  input logic             char_rx_i,
  input logic             wait_cmd_i,
  input logic             restart_cmd_i,
  input logic             irq_en_i,
  input logic             tmo_flag_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] lim_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_q
);
  // R2
  lim_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_q == '0) |=> !tmo_flag_o);

  // R3
  cnt_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(char_rx_i || wait_cmd_i || restart_cmd_i) |=> (cnt_q <= $past(cnt_q)));

  // R5
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_flag_o && !wait_cmd_i && !restart_cmd_i && lim_q != '0)
      |=> (tmo_flag_o && cnt_q == '0 && !run_q));

  // R6
  wait_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cmd_i |=> (!tmo_flag_o && !run_q));

  // R7
  restart_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_cmd_i && !wait_cmd_i) |=> (!tmo_flag_o && run_q && cnt_q == $past(lim_q)));

  // R10
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (tmo_flag_o && irq_en_i));

  // R8
  char_beats_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_rx_i && bit_tick_i && !tmo_flag_o && !wait_cmd_i) |=> (cnt_q == $past(lim_q)));
endmodule

bind rx_idle_timer rx_idle_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bit_tick_i    (bit_tick_i),
  .char_rx_i     (char_rx_i),
  .wait_cmd_i    (wait_cmd_i),
  .restart_cmd_i (restart_cmd_i),
  .irq_en_i      (irq_en_i),
  .tmo_flag_o    (tmo_flag_o),
  .irq_o         (irq_o),
  .lim_q         (lim_q),
  .cnt_q         (cnt_q),
  .run_q         (run_q)
);

// File: tb/rx_idle_timer_bench.sv
`timescale 1ns/1ps
module rx_idle_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, chr, wr, wcmd, rcmd, ien;
  logic [15:0] lim;
  logic        flag, irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rx_idle_timer u_rx_idle_timer (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .char_rx_i(chr),
    .limit_i(lim), .limit_wr_i(wr), .wait_cmd_i(wcmd), .restart_cmd_i(rcmd),
    .irq_en_i(ien), .tmo_flag_o(flag), .irq_o(irq)
  );

  // behavioural reference model
  int m_lim, m_cnt;
  bit m_run, m_flag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lim = 0; m_cnt = 0; m_run = 0; m_flag = 0;
    end else begin
      int nl;
      nl = wr ? int'(lim) : m_lim;
      if (wcmd) begin
        m_flag = 0; m_run = 0; m_cnt = m_lim;
      end else if (rcmd) begin
        m_flag = 0; m_run = 1; m_cnt = m_lim;
      end else if (chr && !m_flag) begin
        m_run = 1; m_cnt = m_lim;
      end else if (tick && m_run && m_lim != 0) begin
        if (m_cnt <= 1) begin
          m_cnt = 0; m_run = 0; m_flag = 1;
        end else m_cnt = m_cnt - 1;
      end
      if (m_lim == 0) m_flag = 0;
      m_lim = nl;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      tests++;
      if (flag !== m_flag || irq !== (m_flag && ien)) begin
        fails++;
        $display("FAIL R3 model: flag=%0b irq=%0b expected flag=%0b irq=%0b",
                 flag, irq, m_flag, m_flag && ien);
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(bit t, bit c, bit w, bit r, bit we = 0, int v = 0);
    tick = t; chr = c; wcmd = w; rcmd = r; wr = we; lim = 16'(v);
    @(negedge clk);
    tick = 0; chr = 0; wcmd = 0; rcmd = 0; wr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 0; tick = 0; chr = 0; wr = 0; wcmd = 0; rcmd = 0; ien = 0; lim = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset flag", flag, 1'b0);
    check("R1 reset irq", irq, 1'b0);
    cyc(0, 0, 0, 0, 1, 5);
    ticks(10);
    check("R1 stopped after reset", flag, 1'b0);

    // R3 countdown after character
    cyc(0, 1, 0, 0);
    ticks(4);
    check("R3 N-1 ticks", flag, 1'b0);
    ticks(1);
    check("R3 N ticks", flag, 1'b1);

    // R10 interrupt gating
    check("R10 irq disabled", irq, 1'b0);
    ien = 1; #1;
    check("R10 irq enabled", irq, 1'b1);

    // R5 sticky flag
    cyc(0, 1, 0, 0);
    ticks(10);
    check("R5 char and ticks keep flag", flag, 1'b1);

    // R6 wait command
    cyc(0, 0, 1, 0);
    check("R6 wait clears", flag, 1'b0);
    check("R10 irq follows flag low", irq, 1'b0);
    ticks(12);
    check("R6 no count before char", flag, 1'b0);
    cyc(0, 1, 0, 0);
    ticks(4);
    check("R6 after char N-1", flag, 1'b0);
    ticks(1);
    check("R6 after char N", flag, 1'b1);

    // R7 restart, periodic
    cyc(0, 0, 0, 1);
    check("R7 restart clears", flag, 1'b0);
    ticks(5);
    check("R7 first period", flag, 1'b1);
    cyc(0, 0, 0, 1);
    ticks(4);
    check("R7 second period N-1", flag, 1'b0);
    ticks(1);
    check("R7 second period", flag, 1'b1);

    // R4 character reload mid-count
    cyc(0, 0, 0, 1);
    ticks(3);
    cyc(0, 1, 0, 0);
    ticks(4);
    check("R4 reload restarts count", flag, 1'b0);
    ticks(1);
    check("R4 N after reload", flag, 1'b1);

    // R8 char and tick together
    cyc(0, 0, 0, 1);
    ticks(4);
    cyc(1, 1, 0, 0);
    ticks(4);
    check("R8 tick swallowed", flag, 1'b0);
    ticks(1);
    check("R8 full period after reload", flag, 1'b1);

    // R9 command beats character, wait beats restart
    cyc(0, 1, 1, 0);
    ticks(10);
    check("R9 wait beats char", flag, 1'b0);
    cyc(0, 0, 0, 1);
    ticks(2);
    cyc(0, 0, 1, 1);
    ticks(10);
    check("R9 wait beats restart", flag, 1'b0);

    // R11 new limit used at next reload
    cyc(0, 0, 0, 1);
    ticks(1);
    cyc(0, 0, 0, 0, 1, 3);
    ticks(3);
    check("R11 old limit still counting", flag, 1'b0);
    ticks(1);
    check("R11 old limit expires", flag, 1'b1);
    cyc(0, 0, 0, 1);
    ticks(2);
    check("R11 new limit N-1", flag, 1'b0);
    ticks(1);
    check("R11 new limit applies", flag, 1'b1);

    // R2 zero limit disables
    cyc(0, 0, 0, 0, 1, 0);
    @(negedge clk);
    check("R2 writing zero clears flag", flag, 1'b0);
    cyc(0, 0, 0, 1);
    ticks(50);
    cyc(0, 1, 0, 0);
    ticks(50);
    check("R2 disabled never flags", flag, 1'b0);

    // R12 maximum limit
    cyc(0, 0, 0, 0, 1, 65535);
    cyc(0, 0, 0, 1);
    ticks(65534);
    check("R12 65534 ticks", flag, 1'b0);
    ticks(1);
    check("R12 65535 ticks", flag, 1'b1);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule